// File: doc/BRIEF.md
# Serial Link Out-of-Band Handshake Sequencer

This block is the host side of the out-of-band exchange that a serial storage link performs before it carries any data. It asks the line transmitter for bursts of signalling or for electrical idle, and it reads burst start and end strobes from the receiver's squelch logic. It sorts what the far end sends into two kinds of pattern, using only the length of the idle gaps between bursts. Burst content is never examined, because every burst has the same fixed size.

A session opens with the host's reset pattern, which uses long gaps. The host then waits for the device's init pattern, which also uses long gaps. Next the host sends its wake pattern, which uses short gaps, and waits for the device to answer with a wake pattern of its own. Each waiting step has a time limit. When the limit runs out, the block starts again from the reset pattern and emits a one-cycle retry error. When the exchange completes, the block raises `link_ready` so that speed negotiation can take over. The link stays up until an init pattern arrives without being expected.

Top module: `oob_seq`

## Requirements
- R1: While reset is held, `oob_state` is 0 (send reset pattern), and `link_ready`, `retry_err` and `tx_burst` are all 0. After reset is released, the block starts sending the reset pattern at once.
- R2: Every transmitted pattern is TX_BURSTS bursts long. Each burst holds `tx_burst` high for BURST_CYC cycles. The low gap between bursts is LONG_GAP cycles in state 0 and SHORT_GAP cycles in state 2. The block leaves the send state on the clock edge that ends the last burst.
- R3: `tx_idle` equals (not `tx_burst`) and (not `link_ready`).
- R4: A gap is the number of cycles from a `rx_burst_end` strobe to the next `rx_burst_start` strobe. A gap within [LONG_MIN, LONG_MAX] is a long gap, and a gap within [SHORT_MIN, SHORT_MAX] is a short gap. Both bounds are inclusive. A pattern is recognised once RUN_LEN consecutive bursts are separated by gaps of the same kind: long gaps mean init, short gaps mean wake.
- R5: A gap outside both windows resets the burst run. Only the bursts that follow such a gap count toward RUN_LEN.
- R6: The state codes are 0 (send reset), 1 (wait for init), 2 (send wake), 3 (wait for wake) and 4 (link up). The normal order is 0, 1, 2, 3, 4. State 1 moves to 2 when an init pattern is recognised, and state 3 moves to 4 when a wake pattern is recognised.
- R7: A wake pattern received in state 1 or state 4 has no effect on the state.
- R8: After TIMEOUT cycles in state 1 or state 3 with no recognised pattern, the state returns to 0. `retry_err` is high for exactly the first cycle of state 0.
- R9: `link_ready` is high exactly while the state is 4. An init pattern recognised in state 4 returns the state to 0.
- R10: `tx_burst` stays low in states 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_burst_start | input | 1 | One-cycle strobe: received burst begins |
| rx_burst_end | input | 1 | One-cycle strobe: received burst ends |
| tx_burst | output | 1 | Request the transmitter to send burst signalling |
| tx_idle | output | 1 | Request electrical idle from the transmitter |
| oob_state | output | 3 | Handshake state code (see R6) |
| link_ready | output | 1 | Handshake complete; speed negotiation may begin |
| retry_err | output | 1 | One-cycle pulse when a wait times out |

## Verification
The case hardest to reach from the ports is a timeout while waiting for the device's wake pattern. Getting there means finishing a full reset and init exchange, letting the host's wake pattern run to its end, and then staying silent for the whole time limit. The stimulus plays device patterns with exact strobe spacing. It first walks the link up and back down through an unexpected init, and only then withholds the answer. A second hard case is a run that a single gap, one cycle short of the long window, splits into two runs. Each half is three bursts long, so neither half alone is enough to be recognised.

// File: rtl/oob_pkg.sv
package oob_pkg;
    typedef enum logic [2:0] {
        ST_SEND_RST  = 3'd0,
        ST_WAIT_INIT = 3'd1,
        ST_SEND_WAKE = 3'd2,
        ST_WAIT_WAKE = 3'd3,
        ST_LINK_UP   = 3'd4
    } oob_state_e;

    typedef enum logic [1:0] {
        GAP_NONE  = 2'd0,
        GAP_SHORT = 2'd1,
        GAP_LONG  = 2'd2
    } gap_kind_e;
endpackage

// File: rtl/oob_gap_classifier.sv
module oob_gap_classifier
    import oob_pkg::*;
#(
    parameter int SHORT_MIN = 12,
    parameter int SHORT_MAX = 20,
    parameter int LONG_MIN  = 40,
    parameter int LONG_MAX  = 56,
    parameter int RUN_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_start,
    input  logic rx_end,
    output logic wake_det,
    output logic init_det
);
    localparam int GW = $clog2(LONG_MAX + 2);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [GW-1:0] SMIN_C = GW'(SHORT_MIN);
    localparam logic [GW-1:0] SMAX_C = GW'(SHORT_MAX);
    localparam logic [GW-1:0] LMIN_C = GW'(LONG_MIN);
    localparam logic [GW-1:0] LMAX_C = GW'(LONG_MAX);
    localparam logic [GW-1:0] SAT_C  = {GW{1'b1}};
    localparam logic [RW-1:0] GAPS_C = RW'(RUN_LEN - 1);

    typedef struct packed {
        logic            in_gap;
        logic [GW-1:0]   gap_cnt;
        gap_kind_e       run_kind;
        logic [RW-1:0]   run_cnt;
        logic            wake_det;
        logic            init_det;
    } cls_t;

    cls_t q, d;

    function automatic gap_kind_e classify(input logic [GW-1:0] g);
        if (g >= LMIN_C && g <= LMAX_C)      classify = GAP_LONG;
        else if (g >= SMIN_C && g <= SMAX_C) classify = GAP_SHORT;
        else                                 classify = GAP_NONE;
    endfunction

    always_comb begin
        gap_kind_e     kind;
        logic [RW-1:0] cnt;
        kind = GAP_NONE;
        cnt  = '0;
        d = q;
        d.wake_det = 1'b0;
        d.init_det = 1'b0;
        if (q.in_gap && q.gap_cnt != SAT_C) d.gap_cnt = q.gap_cnt + 1'b1;
        if (rx_end) begin
            d.in_gap  = 1'b1;
            d.gap_cnt = GW'(1);
        end else if (rx_start) begin
            d.in_gap = 1'b0;
            if (q.in_gap) begin
                kind = classify(q.gap_cnt);
                if (kind == GAP_NONE) begin
                    d.run_cnt  = '0;
                    d.run_kind = GAP_NONE;
                end else begin
                    cnt = (kind == q.run_kind) ? q.run_cnt + 1'b1 : RW'(1);
                    if (cnt == GAPS_C) begin
                        d.wake_det = (kind == GAP_SHORT);
                        d.init_det = (kind == GAP_LONG);
                        d.run_cnt  = '0;
                        d.run_kind = GAP_NONE;
                    end else begin
                        d.run_cnt  = cnt;
                        d.run_kind = kind;
                    end
                end
            end else begin
                d.run_cnt  = '0;
                d.run_kind = GAP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.in_gap   <= 1'b0;
            q.gap_cnt  <= '0;
            q.run_kind <= GAP_NONE;
            q.run_cnt  <= '0;
            q.wake_det <= 1'b0;
            q.init_det <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wake_det = q.wake_det;
    assign init_det = q.init_det;
endmodule

// File: rtl/oob_tx_gen.sv
module oob_tx_gen #(
    parameter int BURST_CYC = 8,
    parameter int TX_BURSTS = 6,
    parameter int SHORT_GAP = 16,
    parameter int LONG_GAP  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic long_sel,
    output logic tx_burst,
    output logic done
);
    localparam int MAXG = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
    localparam int MAXC = (MAXG > BURST_CYC) ? MAXG : BURST_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int NW   = $clog2(TX_BURSTS + 1);
    localparam logic [CW-1:0] BEND_C = CW'(BURST_CYC - 1);
    localparam logic [CW-1:0] LEND_C = CW'(LONG_GAP - 1);
    localparam logic [CW-1:0] SEND_C = CW'(SHORT_GAP - 1);
    localparam logic [NW-1:0] LAST_C = NW'(TX_BURSTS - 1);

    typedef struct packed {
        logic          busy;
        logic          in_burst;
        logic          long_q;
        logic [CW-1:0] cnt;
        logic [NW-1:0] nb;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (go) begin
            d.busy     = 1'b1;
            d.in_burst = 1'b1;
            d.long_q   = long_sel;
            d.cnt      = '0;
            d.nb       = '0;
        end else if (q.busy) begin
            if (q.in_burst) begin
                if (q.cnt == BEND_C) begin
                    d.cnt      = '0;
                    d.in_burst = 1'b0;
                    if (q.nb == LAST_C) begin
                        d.busy = 1'b0;
                        done   = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.cnt == (q.long_q ? LEND_C : SEND_C)) begin
                    d.cnt      = '0;
                    d.in_burst = 1'b1;
                    d.nb       = q.nb + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy     <= 1'b0;
            q.in_burst <= 1'b0;
            q.long_q   <= 1'b1;
            q.cnt      <= '0;
            q.nb       <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_burst = q.busy & q.in_burst;
endmodule

// File: rtl/oob_seq_fsm.sv
module oob_seq_fsm
    import oob_pkg::*;
#(
    parameter int TIMEOUT = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_done,
    input  logic       init_det,
    input  logic       wake_det,
    output logic       go,
    output logic       long_sel,
    output oob_state_e state,
    output logic       retry_err
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] TLAST_C = TW'(TIMEOUT - 1);

    typedef struct packed {
        oob_state_e    state;
        logic [TW-1:0] timer;
        logic          go;
        logic          long_sel;
        logic          err;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d     = q;
        d.go  = 1'b0;
        d.err = 1'b0;
        unique case (q.state)
            ST_SEND_RST: begin
                if (tx_done) begin
                    d.state = ST_WAIT_INIT;
                    d.timer = '0;
                end
            end
            ST_WAIT_INIT: begin
                if (init_det) begin
                    d.state    = ST_SEND_WAKE;
                    d.go       = 1'b1;
                    d.long_sel = 1'b0;
                end else if (q.timer == TLAST_C) begin
                    d.state    = ST_SEND_RST;
                    d.go       = 1'b1;
                    d.long_sel = 1'b1;
                    d.err      = 1'b1;
                end else begin
                    d.timer = q.timer + 1'b1;
                end
            end
            ST_SEND_WAKE: begin
                if (tx_done) begin
                    d.state = ST_WAIT_WAKE;
                    d.timer = '0;
                end
            end
            ST_WAIT_WAKE: begin
                if (wake_det) begin
                    d.state = ST_LINK_UP;
                end else if (q.timer == TLAST_C) begin
                    d.state    = ST_SEND_RST;
                    d.go       = 1'b1;
                    d.long_sel = 1'b1;
                    d.err      = 1'b1;
                end else begin
                    d.timer = q.timer + 1'b1;
                end
            end
            ST_LINK_UP: begin
                if (init_det) begin
                    d.state    = ST_SEND_RST;
                    d.go       = 1'b1;
                    d.long_sel = 1'b1;
                end
            end
            default: begin
                d.state    = ST_SEND_RST;
                d.go       = 1'b1;
                d.long_sel = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_SEND_RST;
            q.timer    <= '0;
            q.go       <= 1'b1;
            q.long_sel <= 1'b1;
            q.err      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign go        = q.go;
    assign long_sel  = q.long_sel;
    assign state     = q.state;
    assign retry_err = q.err;
endmodule

// File: rtl/oob_seq.sv
module oob_seq
    import oob_pkg::*;
#(
    parameter int BURST_CYC = 8,
    parameter int TX_BURSTS = 6,
    parameter int SHORT_GAP = 16,
    parameter int LONG_GAP  = 48,
    parameter int SHORT_MIN = 12,
    parameter int SHORT_MAX = 20,
    parameter int LONG_MIN  = 40,
    parameter int LONG_MAX  = 56,
    parameter int RUN_LEN   = 4,
    parameter int TIMEOUT   = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_burst_start,
    input  logic       rx_burst_end,
    output logic       tx_burst,
    output logic       tx_idle,
    output logic [2:0] oob_state,
    output logic       link_ready,
    output logic       retry_err
);
    logic       go, long_sel, tx_done, wake_det, init_det;
    oob_state_e state;

    oob_gap_classifier #(
        .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
        .LONG_MIN(LONG_MIN), .LONG_MAX(LONG_MAX), .RUN_LEN(RUN_LEN)
    ) i_cls (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_burst_start), .rx_end(rx_burst_end),
        .wake_det(wake_det), .init_det(init_det)
    );

    oob_tx_gen #(
        .BURST_CYC(BURST_CYC), .TX_BURSTS(TX_BURSTS),
        .SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)
    ) i_gen (
        .clk(clk), .rst_n(rst_n), .go(go), .long_sel(long_sel),
        .tx_burst(tx_burst), .done(tx_done)
    );

    oob_seq_fsm #(.TIMEOUT(TIMEOUT)) i_fsm (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done),
        .init_det(init_det), .wake_det(wake_det),
        .go(go), .long_sel(long_sel), .state(state), .retry_err(retry_err)
    );

    assign oob_state  = state;
    assign link_ready = (state == ST_LINK_UP);
    assign tx_idle    = ~tx_burst & ~link_ready;
endmodule

// File: rtl/oob_seq_chk.sv
module oob_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_burst,
    input logic       tx_idle,
    input logic [2:0] oob_state,
    input logic       link_ready,
    input logic       retry_err
);
    AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_burst && tx_idle)); // R3

    AST_QUIET_WHEN_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (oob_state == 3'd1 || oob_state == 3'd3 || oob_state == 3'd4) |-> !tx_burst); // R10

    AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |=> !retry_err); // R8

    AST_RETRY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |-> (oob_state == 3'd0 &&
                       ($past(oob_state) == 3'd1 || $past(oob_state) == 3'd3))); // R8

    AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $past(oob_state) == 3'd3); // R6

    AST_WAKE_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (oob_state == 3'd2 && $past(oob_state) != 3'd2) |-> $past(oob_state) == 3'd1); // R6
endmodule

bind oob_seq oob_seq_chk i_oob_seq_chk (
    .clk(clk), .rst_n(rst_n), .tx_burst(tx_burst), .tx_idle(tx_idle),
    .oob_state(oob_state), .link_ready(link_ready), .retry_err(retry_err)
);

// File: tb/test_oob_seq.sv
`timescale 1ns/1ps
module test_oob_seq;
    localparam int BC   = 8;
    localparam int TXB  = 6;
    localparam int SG   = 16;
    localparam int LG   = 48;
    localparam int SMIN = 12;
    localparam int SMAX = 20;
    localparam int LMIN = 40;
    localparam int LMAX = 56;
    localparam int RUN  = 4;
    localparam int TOUT = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_s = 1'b0;
    logic rx_e = 1'b0;
    logic tx_burst, tx_idle, link_ready, retry_err;
    logic [2:0] oob_state;

    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    oob_seq #(
        .BURST_CYC(BC), .TX_BURSTS(TXB), .SHORT_GAP(SG), .LONG_GAP(LG),
        .SHORT_MIN(SMIN), .SHORT_MAX(SMAX), .LONG_MIN(LMIN), .LONG_MAX(LMAX),
        .RUN_LEN(RUN), .TIMEOUT(TOUT)
    ) i_oob_seq (
        .clk(clk), .rst_n(rst_n), .rx_burst_start(rx_s), .rx_burst_end(rx_e),
        .tx_burst(tx_burst), .tx_idle(tx_idle), .oob_state(oob_state),
        .link_ready(link_ready), .retry_err(retry_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: checks transmitted patterns and pops expected state changes
    bit       mon_on = 1'b0;
    logic     prev_tx = 1'b0;
    logic [2:0] prev_st = 3'd0;
    int hi = 0;
    int lo = 0;
    int nb = 0;
    int eg;
    int ev;

    always @(negedge clk) begin
        if (mon_on) begin
            chk(tx_idle == (!tx_burst && !link_ready), "R3", "tx_idle", int'(tx_idle), int'(!tx_burst && !link_ready));
            chk(link_ready == (oob_state == 3'd4), "R9", "link_ready", int'(link_ready), int'(oob_state == 3'd4));
            if (oob_state == 3'd1 || oob_state == 3'd3 || oob_state == 3'd4)
                chk(!tx_burst, "R10", "tx_burst in wait", int'(tx_burst), 0);
            if (tx_burst) begin
                if (!prev_tx) begin
                    eg = (oob_state == 3'd0) ? LG : SG;
                    if (nb > 0) chk(lo == eg, "R2", "gap length", lo, eg);
                    hi = 1;
                end else begin
                    hi++;
                end
            end else begin
                if (prev_tx) begin
                    chk(hi == BC, "R2", "burst length", hi, BC);
                    nb++;
                    lo = 1;
                end else begin
                    lo++;
                end
            end
            if (oob_state != prev_st) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected state", int'(oob_state), -1);
                end else begin
                    ev = exp_q.pop_front();
                    chk(int'(oob_state) == ev, "R6", "state order", int'(oob_state), ev);
                end
                if ((prev_st == 3'd0 && oob_state == 3'd1) || (prev_st == 3'd2 && oob_state == 3'd3))
                    chk(nb == TXB, "R2", "burst count", nb, TXB);
                if (oob_state == 3'd0 || oob_state == 3'd2) nb = 0;
                prev_st = oob_state;
            end
            prev_tx = tx_burst;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait so that the next start strobe lands g cycles after the last end strobe
    task automatic idle_gap(input int g);
        cycles(g - 1);
    endtask

    task automatic rx_bursts(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            if (i > 0) idle_gap(gap);
            rx_s = 1'b1; @(negedge clk); rx_s = 1'b0;
            cycles(BC - 2);
            rx_e = 1'b1; @(negedge clk); rx_e = 1'b0;
        end
    endtask

    task automatic wait_state(input int s, input int lim);
        int c = 0;
        while (int'(oob_state) != s && c < lim) begin
            @(negedge clk);
            c++;
        end
        chk(int'(oob_state) == s, "R6", "reach state", int'(oob_state), s);
    endtask

    task automatic time_wait(input int s);
        int n = 0;
        bit err_seen = 1'b0;
        while (int'(oob_state) == s && n < TOUT + 10) begin
            if (retry_err) err_seen = 1'b1;
            n++;
            @(negedge clk);
        end
        chk(n == TOUT, "R8", "cycles until timeout", n, TOUT);
        chk(!err_seen, "R8", "retry_err during wait", int'(err_seen), 0);
        chk(oob_state == 3'd0 && retry_err, "R8", "retry pulse at restart", int'(retry_err), 1);
        @(negedge clk);
        chk(!retry_err, "R8", "retry pulse width", int'(retry_err), 0);
    endtask

    initial begin
        cycles(4);
        chk(oob_state == 3'd0, "R1", "reset state", int'(oob_state), 0);
        chk(!link_ready && !retry_err && !tx_burst, "R1", "reset outputs",
            int'({link_ready, retry_err, tx_burst}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(tx_burst == 1'b1, "R1", "reset pattern starts", int'(tx_burst), 1);

        exp_q.push_back(1);
        wait_state(1, 1000);

        // R7: a wake pattern while waiting for init is ignored
        idle_gap(100); rx_bursts(RUN, SMAX);
        cycles(3);
        chk(oob_state == 3'd1, "R7", "wake ignored in wait-init", int'(oob_state), 1);

        // R5: a gap one below the long window splits the run into 3 + 3
        idle_gap(100); rx_bursts(3, LMAX); idle_gap(LMIN - 1); rx_bursts(3, LMAX);
        cycles(3);
        chk(oob_state == 3'd1, "R5", "split run not recognised", int'(oob_state), 1);

        // R4: init recognised at the lower window bound
        exp_q.push_back(2); exp_q.push_back(3);
        idle_gap(100); rx_bursts(RUN, LMIN);
        chk(oob_state == 3'd2, "R4", "init recognised", int'(oob_state), 2);
        wait_state(3, 2000);

        // R6/R9: device wake brings the link up
        exp_q.push_back(4);
        idle_gap(100); rx_bursts(RUN, SMIN);
        chk(oob_state == 3'd4 && link_ready, "R9", "link up", int'(oob_state), 4);
        chk(!tx_idle, "R3", "no idle once link up", int'(tx_idle), 0);

        // R7: wake while up is ignored
        idle_gap(100); rx_bursts(RUN, SMAX);
        cycles(3);
        chk(oob_state == 3'd4, "R7", "wake ignored when up", int'(oob_state), 4);

        // R9: unexpected init drops the link
        exp_q.push_back(0); exp_q.push_back(1);
        idle_gap(100); rx_bursts(RUN, LMAX);
        chk(oob_state == 3'd0 && !link_ready, "R9", "init drops link", int'(oob_state), 0);
        wait_state(1, 1000);

        // R8: timeout waiting for init
        exp_q.push_back(0); exp_q.push_back(1);
        time_wait(1);
        wait_state(1, 1000);

        // R8: timeout waiting for wake
        exp_q.push_back(2); exp_q.push_back(3);
        idle_gap(100); rx_bursts(RUN, LMAX);
        wait_state(3, 2000);
        exp_q.push_back(0);
        time_wait(3);

        chk(exp_q.size() == 0, "R6", "all expected states seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R6 watchdog expired: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule